// File: doc/BRIEF.md
# MDIO management master engine

This block is a Clause 22 management master for Ethernet PHYs. Software, or a neighbouring controller, programs a control word that holds an enable bit and a clock divider. It then writes one packed access word that names a PHY, a register, a direction and, for writes, a data value. When the GO bit of that word is set, the engine shifts a management frame onto a tri-state MDIO line. It clocks the frame with an MDC derived from the system clock. It reports completion by clearing GO.

For a read, the engine releases the line after the register address. It then samples the PHY's response. If the PHY drove the line low in the second turnaround slot, the engine sets ACK and places the sixteen bits it received in the data field. An IDLE status bit shows whether a frame is on the wire. Clearing the enable bit keeps pending commands from starting, but it lets a frame that has already begun run to its end.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000 plus the reset divider: IDLE=1 at bit 31, ENABLE=0 at bit 30, divider in bits 15:0. The access word reads zero, and MDC, MDIO output enable and the driven MDIO level are 0, 0 and 1.
- R2: While a frame runs, one MDC period lasts divider+1 system clocks. A divider of 0 behaves like 1. MDC stays low while no frame runs.
- R3: A write frame is 32 ones, then start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10 and the 16 data bits, all MSB first. The master drives all 64 bits.
- R4: A read frame carries opcode 10. The master drives only the first 46 bits. Output enable is low from the first turnaround bit (bit index 46 counted from 0) to the end of the frame.
- R5: If the PHY drives the second turnaround bit (index 47) low, the read completes with ACK (access bit 29) set. Access bits 15:0 then hold the 16 bits the PHY sent at indices 48..63, first bit in bit 15.
- R6: If the second turnaround bit is sampled high, the read completes with ACK clear.
- R7: The access word bit layout is: GO at 31, WRITE at 30 (0 = read), ACK at 29, register address at 25:21, PHY address at 20:16, data at 15:0. GO stays set from acceptance until the last frame bit ends, and then clears. IDLE (control bit 31) is 0 while a frame runs. A write leaves ACK clear.
- R8: A write to the access word while GO is set changes no field and starts no further frame.
- R9: While ENABLE is clear, a pending GO starts no frame, IDLE stays 1 and MDC stays low. The frame starts once ENABLE is set.
- R10: Clearing ENABLE during a frame lets that frame finish normally. IDLE is then 1.
- R11: The driven MDIO level changes only at MDC falling edges and stays stable while MDC is high. Read bits are sampled at MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word write data (bit 30 enable, bits 15:0 divider) |
| ctl_rdata | output | 32 | Control word readback (bit 31 idle) |
| acc_wr | input | 1 | Write strobe for the access word |
| acc_wdata | input | 32 | Access word write data |
| acc_rdata | output | 32 | Access word readback with GO, ACK and read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Level driven on MDIO when enabled |
| mdio_oe | output | 1 | Output enable for the MDIO driver |
| mdio_i | input | 1 | Level seen on the MDIO line |

## Verification
The bench acts as a PHY. It decodes every frame bit by bit at MDC rising edges and compares it with what its scoreboard expects. It checks the MDC period for dividers of 0, 1, 2 and 3, and odd divisors catch a half-period computed with the wrong rounding. A design that drove through the turnaround would show output enable high at index 46. A design that sampled ACK one bit off would flag an acknowledged read as failed. A design that shifted data at the rising edge would show MDIO changing while MDC is high.

The bench also writes over a command in flight, issues GO while the engine is disabled, and disables the engine mid-frame. A design that dropped the GO guard would corrupt the address fields or send a second frame. A design that aborted on disable would leave the scoreboard with a truncated frame and never clear GO.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int DIV_W    = 16;
    localparam int DAT_W    = 16;
    localparam int PRE_BITS = 32;
    localparam int FRM_BITS = 32;
    localparam int TOT_BITS = PRE_BITS + FRM_BITS;
    localparam int IDX_W    = $clog2(TOT_BITS);

    // bit indices within the 64-bit transfer, counted from 0
    localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PRE_BITS);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + 14);
    localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(PRE_BITS + 15);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_BITS + 16);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOT_BITS - 1);

    typedef struct packed {
        logic             go;
        logic             wr;
        logic             ack;
        logic [2:0]       rsvd;
        logic [4:0]       regad;
        logic [4:0]       phyad;
        logic [DAT_W-1:0] data;
    } acc_word_t;

    typedef struct packed {
        logic             wr;
        logic [4:0]       phyad;
        logic [4:0]       regad;
        logic [DAT_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic             ack;
        logic [DAT_W-1:0] rdata;
    } rsp_t;

    function automatic logic [FRM_BITS-1:0] build_frame(cmd_t c);
        logic [1:0] op;
        logic [1:0] ta;
        op = c.wr ? 2'b01 : 2'b10;
        ta = c.wr ? 2'b10 : 2'b11;
        return {2'b01, op, c.phyad, c.regad, ta, c.wr ? c.data : {DAT_W{1'b1}}};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         mdc,
    output logic         rise,
    output logic         fall
);
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_nx;
    logic [W:0]   span;
    logic [W-1:0] half;

    assign span   = {1'b0, div} + 1'b1;
    assign half   = span[W:1];
    assign cnt_nx = (cnt == div) ? '0 : cnt + 1'b1;
    // strobes mark the clock edge at which MDC changes
    assign rise   = run && (cnt_nx == half);
    assign fall   = run && (cnt_nx == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt_nx;
            mdc <= (cnt_nx >= half);
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cmd_t cmd,
    input  logic rise,
    input  logic fall,
    input  logic mdc,
    input  logic mdio_i,
    output logic busy,
    output logic done,
    output rsp_t rsp,
    output logic mdio_o,
    output logic mdio_oe
);
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    nidx;
    logic [FRM_BITS-1:0] frm;
    logic                wr_q;
    logic                ack_q;
    logic [DAT_W-1:0]    sh;

    assign nidx = idx + 1'b1;
    assign done = busy && fall && (idx == LAST_IDX);
    assign rsp  = '{ack: ack_q, rdata: sh};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            frm     <= '0;
            wr_q    <= 1'b0;
            ack_q   <= 1'b0;
            sh      <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                idx     <= '0;
                frm     <= build_frame(cmd);
                wr_q    <= cmd.wr;
                ack_q   <= 1'b0;
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b1;
            end
        end else begin
            if (rise && !wr_q) begin
                if (idx == ACK_IDX) ack_q <= !mdio_i;
                if (idx >= DAT_IDX) sh <= {sh[DAT_W-2:0], mdio_i};
            end
            if (fall) begin
                if (idx == LAST_IDX) begin
                    busy    <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    idx     <= nidx;
                    mdio_oe <= wr_q || (nidx < TA_IDX);
                    if (nidx >= PRE_END) begin
                        mdio_o <= frm[FRM_BITS-1];
                        frm    <= {frm[FRM_BITS-2:0], 1'b0};
                    end else begin
                        mdio_o <= 1'b1;
                    end
                end
            end
        end
    end

    // R11
    mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mdc && $past(mdc)) |-> $stable(mdio_o));
    // R4
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_q && idx >= TA_IDX) |-> !mdio_oe);
    // R3
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_q) |-> mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RST = 16'd7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic        acc_wr,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             en_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_run;
    acc_word_t        acc_q;
    acc_word_t        acc_in;
    cmd_t             cmd;
    rsp_t             rsp;
    logic             busy;
    logic             done;
    logic             start;
    logic             rise;
    logic             fall;

    always_comb begin
        acc_in      = acc_word_t'(acc_wdata);
        acc_in.ack  = 1'b0;
        acc_in.rsvd = '0;
    end

    assign cmd       = '{wr: acc_q.wr, phyad: acc_q.phyad, regad: acc_q.regad, data: acc_q.data};
    assign start     = acc_q.go && en_q && !busy;
    assign ctl_rdata = {!busy, en_q, 14'b0, div_q};
    assign acc_rdata = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            div_q   <= DIV_RST;
            div_run <= DIV_W'(1);
            acc_q   <= '0;
        end else begin
            if (ctl_wr) begin
                en_q  <= ctl_wdata[30];
                div_q <= ctl_wdata[DIV_W-1:0];
            end
            if (start) div_run <= (div_q == '0) ? DIV_W'(1) : div_q;
            if (done) begin
                acc_q.go <= 1'b0;
                if (!acc_q.wr) begin
                    acc_q.ack  <= rsp.ack;
                    acc_q.data <= rsp.rdata;
                end
            end else if (acc_wr && !acc_q.go) begin
                acc_q <= acc_in;
            end
        end
    end

    mdio_clkgen #(.W(DIV_W)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div_run),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_shifter u_shf (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd     (cmd),
        .rise    (rise),
        .fall    (fall),
        .mdc     (mdc),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .done    (done),
        .rsp     (rsp),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    // R7
    go_held_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> acc_q.go);
    // R9
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !busy) |=> !busy);
    // R8
    locked_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_q.go && !done) |=> $stable(acc_q));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam time CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #(CLK_PER/2) clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        bit        wr;
        bit [4:0]  phy;
        bit [4:0]  rg;
        bit [15:0] data;
        bit        ack;
        int        per;
    } item_t;

    item_t   sb_q[$];
    int      n_chk = 0;
    int      n_fail = 0;
    longint  cyc = 0;
    bit      done_flag = 0;

    bit        phy_isrd = 0;
    bit        phy_ack = 0;
    bit [15:0] phy_rd = '0;
    int        nrise = 0;
    logic      mdc_p = 1'b0;
    logic      mdo_p = 1'b1;
    bit        hold_bad = 0;
    logic [63:0] cap_d, cap_oe;
    longint    last_rise = 0;
    longint    per_meas = 0;

    always @(posedge clk) cyc++;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: compares each completed frame with the queued item
    task automatic check_frame();
        item_t       it;
        logic [63:0] exp_d, msk, exp_oe;
        if (sb_q.size() == 0) begin
            chk(0, "R8", "unexpected frame on wire", 1, 0);
            return;
        end
        it     = sb_q.pop_front();
        exp_d  = {32'hFFFF_FFFF, 2'b01, (it.wr ? 2'b01 : 2'b10), it.phy, it.rg, 2'b10,
                  (it.wr ? it.data : 16'h0)};
        exp_oe = it.wr ? {64{1'b1}} : {{46{1'b1}}, {18{1'b0}}};
        msk    = exp_oe;
        if (it.wr) chk((cap_d & msk) == (exp_d & msk), "R3", "write frame bits", cap_d, exp_d);
        else       chk((cap_d & msk) == (exp_d & msk), "R4", "read frame header", cap_d & msk, exp_d & msk);
        chk(cap_oe == exp_oe, it.wr ? "R3" : "R4", "output enable pattern", cap_oe, exp_oe);
        chk(per_meas == it.per, "R2", "MDC period", per_meas, it.per);
        chk(!hold_bad, "R11", "MDIO moved while MDC high", hold_bad, 0);
        hold_bad = 0;
    endtask

    // PHY model and bit monitor
    always @(negedge clk) begin
        if (rst) begin
            nrise = 0;
            mdc_p = 1'b0;
            mdo_p = mdio_o;
            mdio_i = 1'b1;
        end else begin
            if (mdc && mdc_p && mdio_o !== mdo_p) hold_bad = 1;
            if (mdc && !mdc_p) begin
                cap_d[63-nrise]  = mdio_o;
                cap_oe[63-nrise] = mdio_oe;
                if (nrise == 1) per_meas = cyc - last_rise;
                last_rise = cyc;
                nrise++;
                if (nrise == 64) begin
                    check_frame();
                    nrise = 0;
                end
            end
            if (!mdc && mdc_p) begin
                mdio_i = 1'b1;
                if (phy_isrd && phy_ack) begin
                    if (nrise == 47) mdio_i = 1'b0;
                    else if (nrise >= 48 && nrise < 64) mdio_i = phy_rd[63-nrise];
                end
            end
            mdc_p = mdc;
            mdo_p = mdio_o;
        end
    end

    task automatic wr_ctl(bit en, bit [15:0] dv);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = {1'b0, en, 14'b0, dv};
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_acc(bit go, bit wr, bit [4:0] rg, bit [4:0] phy, bit [15:0] d);
        @(negedge clk);
        acc_wr = 1'b1;
        acc_wdata = {go, wr, 1'b0, 3'b0, rg, phy, d};
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    // driver: pushes the expected item, then issues the command
    task automatic issue(item_t it);
        sb_q.push_back(it);
        phy_isrd = !it.wr;
        phy_ack  = it.ack;
        phy_rd   = it.data;
        wr_acc(1'b1, it.wr, it.rg, it.phy, it.wr ? it.data : 16'h0);
    endtask

    task automatic wait_done();
        while (acc_rdata[31]) @(negedge clk);
    endtask

    task automatic check_result(item_t it, string req);
        chk(acc_rdata[31] == 1'b0, "R7", "GO after completion", acc_rdata[31], 0);
        chk(acc_rdata[25:16] == {it.rg, it.phy}, req, "address fields kept", acc_rdata[25:16], {it.rg, it.phy});
        if (it.wr) begin
            chk(acc_rdata[29] == 1'b0, "R7", "ACK after write", acc_rdata[29], 0);
        end else if (it.ack) begin
            chk(acc_rdata[29] == 1'b1, "R5", "ACK after answered read", acc_rdata[29], 1);
            chk(acc_rdata[15:0] == it.data, "R5", "read data", acc_rdata[15:0], it.data);
        end else begin
            chk(acc_rdata[29] == 1'b0, "R6", "ACK after unanswered read", acc_rdata[29], 0);
        end
        @(negedge clk);
        chk(ctl_rdata[31] == 1'b1, "R7", "IDLE after completion", ctl_rdata[31], 1);
    endtask

    task automatic run(item_t it);
        issue(it);
        @(negedge clk);
        chk(acc_rdata[31] == 1'b1, "R7", "GO while pending", acc_rdata[31], 1);
        chk(ctl_rdata[31] == 1'b0, "R7", "IDLE while busy", ctl_rdata[31], 0);
        wait_done();
        check_result(it, "R7");
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        item_t it;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ctl_rdata == 32'h8000_0007, "R1", "control word", ctl_rdata, 32'h8000_0007);
        chk(acc_rdata == 32'h0, "R1", "access word", acc_rdata, 0);
        chk({mdc, mdio_oe, mdio_o} == 3'b001, "R1", "pins", {mdc, mdio_oe, mdio_o}, 3'b001);

        wr_ctl(1'b1, 16'd3);
        it = '{wr: 1, phy: 5'h05, rg: 5'h1A, data: 16'hBEEF, ack: 0, per: 4};
        run(it);                                           // R3 write, R2 even divider
        it = '{wr: 0, phy: 5'h1F, rg: 5'h02, data: 16'h1234, ack: 1, per: 4};
        run(it);                                           // R4, R5
        it = '{wr: 0, phy: 5'h00, rg: 5'h1F, data: 16'h0, ack: 0, per: 4};
        run(it);                                           // R6

        wr_ctl(1'b1, 16'd1);
        it = '{wr: 1, phy: 5'h15, rg: 5'h0A, data: 16'h5A0F, ack: 0, per: 2};
        run(it);                                           // R2 fastest
        wr_ctl(1'b1, 16'd0);
        it = '{wr: 0, phy: 5'h0C, rg: 5'h13, data: 16'h8001, ack: 1, per: 2};
        run(it);                                           // R2 zero divider
        wr_ctl(1'b1, 16'd2);
        it = '{wr: 0, phy: 5'h11, rg: 5'h04, data: 16'hFFFE, ack: 1, per: 3};
        run(it);                                           // R2 odd divisor

        // R8 write while GO set is ignored
        wr_ctl(1'b1, 16'd3);
        it = '{wr: 0, phy: 5'h09, rg: 5'h11, data: 16'hA5C3, ack: 1, per: 4};
        issue(it);
        repeat (20) @(negedge clk);
        wr_acc(1'b1, 1'b1, 5'h03, 5'h04, 16'h7777);
        chk(acc_rdata[31:16] == {1'b1, 1'b0, 1'b0, 3'b0, 5'h11, 5'h09}, "R8", "fields after blocked write",
            acc_rdata[31:16], {1'b1, 1'b0, 1'b0, 3'b0, 5'h11, 5'h09});
        wait_done();
        check_result(it, "R8");
        repeat (300) @(negedge clk);
        chk(nrise == 0 && sb_q.size() == 0 && ctl_rdata[31], "R8", "no extra frame", nrise, 0);

        // R9 disabled engine holds a pending command
        wr_ctl(1'b0, 16'd3);
        it = '{wr: 1, phy: 5'h1E, rg: 5'h07, data: 16'h0F0F, ack: 0, per: 4};
        issue(it);
        repeat (200) @(negedge clk);
        chk(acc_rdata[31] == 1'b1, "R9", "GO held while disabled", acc_rdata[31], 1);
        chk(ctl_rdata[31] == 1'b1, "R9", "IDLE while disabled", ctl_rdata[31], 1);
        chk(nrise == 0 && mdc == 1'b0, "R9", "MDC quiet while disabled", nrise, 0);
        wr_ctl(1'b1, 16'd3);
        wait_done();
        check_result(it, "R9");
        chk(sb_q.size() == 0, "R9", "frame sent after enable", sb_q.size(), 0);

        // R10 disable during a frame
        it = '{wr: 0, phy: 5'h02, rg: 5'h19, data: 16'h3C96, ack: 1, per: 4};
        issue(it);
        repeat (40) @(negedge clk);
        wr_ctl(1'b0, 16'd3);
        chk(ctl_rdata[31] == 1'b0, "R10", "frame still running", ctl_rdata[31], 0);
        wait_done();
        check_result(it, "R10");
        chk(ctl_rdata[31:30] == 2'b10, "R10", "idle and disabled", ctl_rdata[31:30], 2'b10);
        chk(sb_q.size() == 0, "R10", "whole frame seen", sb_q.size(), 0);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule